// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block produces one edge-aligned, high-true pulse-width-modulated output. The output is derived from a free-running up-counter that restarts after a programmable modulo. A prescaler in front of the counter sets how many system clocks each count lasts: either one clock, for the finest resolution, or `PRE_DIV` clocks (64 by default), for longer periods. Software drives the block through a single-cycle write port with four addresses: control, modulo, compare and counter restart.

Both the compare value and the modulo are double-buffered and reach the active registers only at a cycle boundary. The compare buffer takes a single write per PWM cycle. Any further compare write before the boundary is discarded, and a sticky flag records the loss. A write to the restart address ends the current cycle at once, which loads any pending value and frees the compare buffer. The counter, the active modulo and the active compare value are brought out as registered status outputs.

Top module: `pwm_edge_timer`

## Requirements
- R1: After reset, `cnt_o` = 0, `cmp_o` = 0, `mod_o` = 0xFFFF, `pwm_o` = 0 and `drop_o` = 0, and the timer is disabled.
- R2: While enabled, `cnt_o` steps 0, 1, …, `mod_o` and then returns to 0, so one PWM period lasts `mod_o` + 1 counts.
- R3: Control bit 1 selects the prescaler. A value of 0 means each count lasts one clock. A value of 1 means each count lasts 64 clocks.
- R4: `pwm_o` is high exactly while `cnt_o` < `cmp_o`, starting at count 0 of each cycle. Each period therefore has min(`cmp_o`, `mod_o` + 1) high counts.
- R5: A compare of 0 gives a constant low output. A compare greater than the modulo gives a constant high output.
- R6: Compare writes go to address 2. Only the first compare write in a PWM cycle is kept. Later compare writes in the same cycle are discarded and do not reach `cmp_o`.
- R7: An accepted compare value becomes active only at the next cycle boundary. Until then, `cmp_o` and the output keep the old value.
- R8: Any write to address 3 clears `cnt_o` to 0 on the next clock and ends the cycle. A pending compare value loads into `cmp_o` on that same clock, and the buffer can take a new write straight away.
- R9: `drop_o` sets when a compare write is discarded. It stays set until a control write (address 0) has bit 2 = 1.
- R10: Modulo writes go to address 1. They take effect at the next wrap or restart. Later modulo writes in the same cycle replace the pending value, so the last one wins.
- R11: Control bit 0 is the enable. While it is 0, the counter is held at 0, `pwm_o` is low, and pending compare and modulo values load on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 2 | 0 control, 1 modulo, 2 compare, 3 counter restart |
| wr_data | input | CNT_W | Write data; control bits: 0 enable, 1 prescaler, 2 clear flag |
| pwm_o | output | 1 | Edge-aligned high-true PWM output |
| cnt_o | output | CNT_W | Current count |
| mod_o | output | CNT_W | Active modulo |
| cmp_o | output | CNT_W | Active compare value |
| drop_o | output | 1 | Sticky discarded-compare flag |

## Verification
Every output is registered, so a write sampled at one clock edge shows its direct effect on the outputs one clock later. This covers enable, restart, flag set and flag clear. A buffered value appears on the clock that closes the cycle, and the bench waits for `cnt_o` to return to 0 before it checks one. The bench drives inputs and samples outputs on the falling edge. From the enable clock onward, it treats the n-th sample as count n modulo (modulo + 1), or as count n/64 under the divide-by-64 setting. Its expected counts and duty come from functions of the programmed modulo and compare values.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_MOD  = 2'd1;
  localparam logic [1:0] ADR_CMP  = 2'd2;
  localparam logic [1:0] ADR_CNT  = 2'd3;
  localparam int CTL_EN  = 0;
  localparam int CTL_DIV = 1;
  localparam int CTL_CLR = 2;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int PRE_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic div_sel,
  output logic tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) pre_q <= '0;
    else if (pre_q == LAST)     pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (!div_sel || (pre_q == LAST));

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (!run || restart) |=> (pre_q == '0)); // R3
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit ONE_PER_CYCLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] act_q,
  output logic [W-1:0] act_d,
  output logic         drop
);
  logic         full_q;
  logic [W-1:0] pend_q;
  logic         accept;

  generate
    if (ONE_PER_CYCLE) begin : g_once
      assign accept = wr && !full_q;
      assign drop   = wr && full_q;
      AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr && full_q && !load) |=> $stable(pend_q)); // R6
    end else begin : g_last
      assign accept = wr;
      assign drop   = 1'b0;
    end
  endgenerate

  assign act_d = (load && full_q) ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
    end else begin
      act_q <= act_d;
      if (accept) begin
        pend_q <= wdata;
        full_q <= 1'b1;
      end else if (load) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_q)); // R7
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         run_d,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] mod_act,
  input  logic [W-1:0] mod_d,
  input  logic [W-1:0] cmp_act,
  input  logic [W-1:0] cmp_d,
  output logic         boundary,
  output logic [W-1:0] cnt_q,
  output logic         pwm_q
);
  logic         wrap;
  logic [W-1:0] cnt_d;

  assign wrap     = (cnt_q == mod_act);
  assign boundary = clr || !run || !run_d || (tick && wrap);

  always_comb begin
    if (!run_d || clr)   cnt_d = '0;
    else if (!tick)      cnt_d = cnt_q;
    else if (wrap)       cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= run_d && (cnt_d < cmp_d);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= mod_act); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run && run_d && !clr && tick && wrap) |=> (cnt_q == '0)); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |-> (cnt_q == '0 && !pwm_q)); // R11
  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmp_act == '0) |-> !pwm_q); // R5
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (run && cmp_act > mod_act) |-> pwm_q); // R5
  AST_MOD_SWAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mod_d != mod_act) |-> (cnt_d == '0)); // R10
endmodule

// File: rtl/pwm_edge_timer.sv
module pwm_edge_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] MOD_RST = {CNT_W{1'b1}};

  logic en_q, div_q, drop_q;
  logic ctrl_wr, mod_wr, cmp_wr, clr_wr;
  logic run_d, tick, boundary;
  logic cmp_drop, mod_drop;
  logic [CNT_W-1:0] mod_d, cmp_d;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign mod_wr  = wr_en && (wr_addr == ADR_MOD);
  assign cmp_wr  = wr_en && (wr_addr == ADR_CMP);
  assign clr_wr  = wr_en && (wr_addr == ADR_CNT);
  assign run_d   = ctrl_wr ? wr_data[CTL_EN] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      div_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      en_q <= run_d;
      if (ctrl_wr) div_q <= wr_data[CTL_DIV];
      if (cmp_drop || mod_drop)              drop_q <= 1'b1;
      else if (ctrl_wr && wr_data[CTL_CLR])  drop_q <= 1'b0;
    end
  end

  pwm_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(en_q), .restart(clr_wr),
    .div_sel(div_q), .tick(tick)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL(MOD_RST), .ONE_PER_CYCLE(1'b0)) u_mod (
    .clk(clk), .rst(rst), .wr(mod_wr), .wdata(wr_data), .load(boundary),
    .act_q(mod_o), .act_d(mod_d), .drop(mod_drop)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0), .ONE_PER_CYCLE(1'b1)) u_cmp (
    .clk(clk), .rst(rst), .wr(cmp_wr), .wdata(wr_data), .load(boundary),
    .act_q(cmp_o), .act_d(cmp_d), .drop(cmp_drop)
  );

  pwm_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(en_q), .run_d(run_d), .clr(clr_wr),
    .tick(tick), .mod_act(mod_o), .mod_d(mod_d), .cmp_act(cmp_o),
    .cmp_d(cmp_d), .boundary(boundary), .cnt_q(cnt_o), .pwm_q(pwm_o)
  );

  assign drop_o = drop_q;

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (cnt_o == '0)); // R8
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (drop_q && !(ctrl_wr && wr_data[CTL_CLR])) |=> drop_q); // R9
  AST_DROP_SETS: assert property (@(posedge clk) disable iff (rst)
    cmp_drop |=> drop_q); // R9
endmodule

// File: tb/pwm_edge_timer_tb.sv
module pwm_edge_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_o, drop_o;
  logic [W-1:0] cnt_o, mod_o, cmp_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_timer #(.CNT_W(W), .PRE_DIV(64)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .cnt_o(cnt_o), .mod_o(mod_o), .cmp_o(cmp_o), .drop_o(drop_o)
  );

  function automatic int exp_high(input int c, input int m);
    return (c < m + 1) ? c : m + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_wrap();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (cnt_o != 0 && guard < 100000);
  endtask

  // Samples n clocks from count 0; div gives clocks per count.
  task automatic measure(input int m, input int c, input int n, input int div,
                         output int ones, output int cnt_err, output int pwm_err);
    ones = 0; cnt_err = 0; pwm_err = 0;
    for (int i = 0; i < n; i++) begin
      int ec;
      ec = (i / div) % (m + 1);
      if (int'(cnt_o) != ec) cnt_err++;
      if (pwm_o !== (ec < c)) pwm_err++;
      if (pwm_o) ones++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int ones, ce, pe, m, c, seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cnt_o == 0, "R1 cnt", int'(cnt_o), 0);
    check(cmp_o == 0, "R1 cmp", int'(cmp_o), 0);
    check(mod_o == 16'hFFFF, "R1 mod", int'(mod_o), 65535);
    check(pwm_o == 0 && drop_o == 0, "R1 pwm/drop", int'({pwm_o, drop_o}), 0);

    // Random vectors with directed corners first (R2, R4, R5)
    for (int v = 0; v < 24; v++) begin
      m = 1 + int'($urandom % 40);
      if (v == 0)      c = 0;
      else if (v == 1) c = m + 1;
      else if (v == 2) c = m;
      else             c = int'($urandom % (m + 3));
      wr(2'd0, 0);
      wr(2'd1, m);
      wr(2'd2, c);
      wr(2'd0, 1);
      measure(m, c, 2 * (m + 1), 1, ones, ce, pe);
      check(ce == 0, "R2 period count errors", ce, 0);
      check(pe == 0, "R4 edge-aligned output errors", pe, 0);
      check(ones == 2 * exp_high(c, m), "R5 high clocks over two periods", ones, 2 * exp_high(c, m));
    end

    // R6, R7, R9: second compare write in one cycle is dropped
    wr(2'd0, 0); wr(2'd1, 49); wr(2'd2, 10); wr(2'd0, 5);
    repeat (3) @(negedge clk);
    wr(2'd2, 20);
    wr(2'd2, 30);
    check(cmp_o == 10, "R7 compare unchanged mid-cycle", int'(cmp_o), 10);
    check(drop_o == 1, "R9 drop flag set", int'(drop_o), 1);
    wait_wrap();
    check(cmp_o == 20, "R6 first write kept", int'(cmp_o), 20);
    measure(49, 20, 50, 1, ones, ce, pe);
    check(ones == 20 && pe == 0, "R6 duty of kept value", ones, 20);
    check(drop_o == 1, "R9 flag still set", int'(drop_o), 1);
    wr(2'd0, 5);
    check(drop_o == 0, "R9 flag cleared", int'(drop_o), 0);

    // R8: counter write ends cycle and loads pending compare
    repeat (4) @(negedge clk);
    wr(2'd2, 40);
    check(cmp_o == 20, "R7 pending not yet active", int'(cmp_o), 20);
    wr(2'd3, 0);
    check(cnt_o == 0, "R8 count cleared", int'(cnt_o), 0);
    check(cmp_o == 40, "R8 pending loaded", int'(cmp_o), 40);
    wr(2'd2, 45);
    check(drop_o == 0, "R8 buffer freed", int'(drop_o), 0);
    wait_wrap();
    check(cmp_o == 45, "R8 new write after restart", int'(cmp_o), 45);

    // R10: modulo buffered, last write wins
    repeat (5) @(negedge clk);
    wr(2'd1, 9);
    wr(2'd1, 19);
    check(mod_o == 49, "R10 modulo held mid-cycle", int'(mod_o), 49);
    wait_wrap();
    check(mod_o == 19, "R10 last modulo active", int'(mod_o), 19);
    measure(19, 45, 40, 1, ones, ce, pe);
    check(ce == 0, "R10 new period", ce, 0);
    check(ones == 40, "R5 compare above modulo is high", ones, 40);

    // R11: disable holds counter and output low
    wr(2'd0, 0);
    ce = 0;
    for (int i = 0; i < 8; i++) begin
      if (cnt_o != 0 || pwm_o != 0) ce++;
      @(negedge clk);
    end
    check(ce == 0, "R11 idle samples not low/zero", ce, 0);

    // R3: divide-by-64
    wr(2'd1, 3); wr(2'd2, 2); wr(2'd0, 3);
    measure(3, 2, 512, 64, ones, ce, pe);
    check(ce == 0, "R3 count per 64 clocks", ce, 0);
    check(ones == 256 && pe == 0, "R3 duty at divide-by-64", ones, 256);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule